// File: doc/BRIEF.md
# Byte-Lane Controller for an Asynchronous Static RAM

This block sits between a synchronous internal bus and an external asynchronous static RAM of 256K words by 16 bits. Each request is one word access: a read or a write, with a two-bit byte enable that picks either or both 8-bit lanes. The controller latches the request and runs the memory's active-low select, output-enable, write-enable and per-lane strobes through a fixed sequence of phases. Once the access is done it returns a one-cycle acknowledge. For a read, the captured word comes back with it.

Every phase length is a cycle count. Each count is derived at elaboration from a clock-period parameter and the memory's nanosecond timing limits, rounding up, with a floor of one cycle. Writes are ended by write enable rising while select stays low. The data-bus drivers switch on only after the memory's worst-case output release time has elapsed. A read that is directly followed by a write gets an extra idle cycle in which all strobes are inactive.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is held and after it is released, mem_cs_n, mem_oe_n and mem_we_n are high, both mem_lane_n bits are high, mem_dq_oe is low, ack is low and rdata is zero.
- R2: A read request with a non-zero byte enable holds mem_cs_n and mem_oe_n low and mem_we_n high for RD_CYC consecutive cycles (14 at the defaults). During those cycles mem_addr equals the request address and mem_lane_n equals the inverted byte enable. Bit 0 of the enable and of mem_lane_n is the lane on data bits 7:0, and bit 1 is the lane on bits 15:8.
- R3: A read raises ack RD_CYC+1 cycles after the accepting edge, which is 15 at the defaults. In that cycle rdata holds the word the memory drove, with any lane that was not enabled returned as zero.
- R4: A write holds mem_we_n low for WP_CYC consecutive cycles (13 at the defaults), always inside a window where mem_cs_n is low. mem_we_n rises one cycle before mem_cs_n does.
- R5: A write changes only the enabled lanes of the addressed word.
- R6: mem_dq_oe is high only during a write and never while mem_oe_n is low. It rises no earlier than HZ_CYC cycles (5 at the defaults) after mem_we_n falls, so it is high for WP_CYC-HZ_CYC cycles of the low write-enable pulse.
- R7: In the cycle after mem_we_n rises, mem_cs_n is still low, mem_dq_oe is high, and mem_dq and mem_addr still carry the write data and address. Ack follows one cycle later, WP_CYC+2 cycles after the accepting edge.
- R8: When a write immediately follows a read, one extra cycle with all strobes high precedes the write, and its ack comes one cycle later than usual.
- R9: A request with byte enable 00 is acknowledged in the cycle after it is accepted and causes no strobe activity.
- R10: A request that arrives while an access is in progress is ignored. It produces no ack and no memory activity.
- R11: Ack is only ever raised while the controller is idle, so a new request may be presented in the ack cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | One-cycle request pulse, accepted only when idle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enable, bit 0 = lower lane |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read data, disabled lanes zero |
| mem_cs_n | output | 1 | Memory select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_lane_n | output | 2 | Per-lane byte strobes, active low, bit 0 = lower lane |
| mem_addr | output | 18 | Memory address bus |
| mem_dq | inout | 16 | Memory data bus |
| mem_dq_oe | output | 1 | Data-bus driver enable |

## Verification
Ack latency depends on the kind of access. A zero-enable request is acknowledged 1 cycle after acceptance, a read after 15, a write after 15, and a write that follows a read after 16. The bench counts falling edges from the accepting rising edge and compares against those figures. The memory-side checks are made at every falling edge of the access: the write-enable low count against 13, the driver-enable count against 8, and the hold cycle right after write enable rises. Read data is compared only in the ack cycle, and stored words are compared once the ack has arrived.

// File: rtl/asram_pkg.sv
`timescale 1ns/1ps
package asram_pkg;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_READ   = 3'd1,
        PH_TURN   = 3'd2,
        PH_WPULSE = 3'd3,
        PH_WHOLD  = 3'd4
    } phase_e;

    // nanoseconds to whole cycles, rounded up, never below one
    function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned clk_ns);
        int unsigned c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/asram_seq.sv
`timescale 1ns/1ps
module asram_seq
    import asram_pkg::*;
#(
    parameter int unsigned RD_CYC = 14,
    parameter int unsigned WP_CYC = 13,
    parameter int unsigned HZ_CYC = 5,
    parameter int unsigned CNT_W  = 4
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   req,
    input  logic   req_we,
    input  logic   be_any,
    output phase_e phase,
    output logic   accept,
    output logic   capture,
    output logic   drive_en,
    output logic   ack
);

    logic [CNT_W-1:0] cnt;
    logic             prev_rd;

    assign accept   = (phase == PH_IDLE) && req;
    assign capture  = (phase == PH_READ) && (cnt == CNT_W'(RD_CYC - 1));
    assign drive_en = ((phase == PH_WPULSE) && (cnt >= CNT_W'(HZ_CYC))) ||
                      (phase == PH_WHOLD);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            cnt     <= '0;
            ack     <= 1'b0;
            prev_rd <= 1'b0;
        end else begin
            ack <= 1'b0;
            unique case (phase)
                PH_IDLE: begin
                    cnt <= '0;
                    if (req) begin
                        if (!be_any)     ack   <= 1'b1;
                        else if (!req_we) phase <= PH_READ;
                        else if (prev_rd) phase <= PH_TURN;
                        else              phase <= PH_WPULSE;
                    end
                end
                PH_READ: begin
                    if (cnt == CNT_W'(RD_CYC - 1)) begin
                        ack     <= 1'b1;
                        prev_rd <= 1'b1;
                        phase   <= PH_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_TURN: begin
                    cnt   <= '0;
                    phase <= PH_WPULSE;
                end
                PH_WPULSE: begin
                    if (cnt == CNT_W'(WP_CYC - 1)) phase <= PH_WHOLD;
                    else                           cnt   <= cnt + 1'b1;
                end
                PH_WHOLD: begin
                    ack     <= 1'b1;
                    prev_rd <= 1'b0;
                    phase   <= PH_IDLE;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // R11: completion is only signalled from idle
    p_ack_idle_r11: assert property (@(posedge clk) disable iff (rst)
        ack |-> phase == PH_IDLE);

    // R8: a write that follows a read passes through the turnaround phase
    p_turn_then_write_r8: assert property (@(posedge clk) disable iff (rst)
        phase == PH_TURN |=> phase == PH_WPULSE);

endmodule

// File: rtl/asram_lanes.sv
`timescale 1ns/1ps
module asram_lanes #(
    parameter int unsigned ADDR_W = 18,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned LANES  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_be,
    input  logic              capture,
    input  logic [DATA_W-1:0] dq_in,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [LANES-1:0]  be_q,
    output logic [DATA_W-1:0] rdata
);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
            be_q    <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            be_q    <= req_be;
        end
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst)
                rdata[i*8 +: 8] <= '0;
            else if (capture)
                rdata[i*8 +: 8] <= be_q[i] ? dq_in[i*8 +: 8] : 8'h00;
        end
    end

    // R3: a disabled lane never carries captured data
    for (genvar i = 0; i < LANES; i++) begin : g_chk
        p_lane_zero_r3: assert property (@(posedge clk) disable iff (rst)
            capture && !be_q[i] |=> rdata[i*8 +: 8] == 8'h00);
    end

endmodule

// File: rtl/asram_ctrl.sv
`timescale 1ns/1ps
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int unsigned ADDR_W = 18,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned CLK_NS = 5,
    parameter int unsigned T_RC   = 70,
    parameter int unsigned T_AA   = 70,
    parameter int unsigned T_WC   = 70,
    parameter int unsigned T_WP   = 55,
    parameter int unsigned T_CW   = 60,
    parameter int unsigned T_DW   = 30,
    parameter int unsigned T_HZ   = 25
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W/8-1:0] req_be,
    output logic              ack,
    output logic [DATA_W-1:0] rdata,
    output logic              mem_cs_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W/8-1:0] mem_lane_n,
    output logic [ADDR_W-1:0] mem_addr,
    inout  wire  [DATA_W-1:0] mem_dq,
    output logic              mem_dq_oe
);

    localparam int unsigned LANES  = DATA_W / 8;
    localparam int unsigned HZ_CYC = ns2cyc(T_HZ, CLK_NS);
    localparam int unsigned RD_CYC = umax(ns2cyc(T_AA, CLK_NS), ns2cyc(T_RC, CLK_NS));
    localparam int unsigned WP_CYC = umax(umax(ns2cyc(T_WP, CLK_NS), ns2cyc(T_CW, CLK_NS)),
                                          umax(HZ_CYC + ns2cyc(T_DW, CLK_NS),
                                               ns2cyc(T_WC, CLK_NS) - 1));
    localparam int unsigned CNT_W  = $clog2(umax(RD_CYC, WP_CYC) + 1);

    phase_e            phase;
    logic              accept, capture, drive_en;
    logic [DATA_W-1:0] wdata_q;
    logic [LANES-1:0]  be_q;
    logic              busy;

    asram_seq #(
        .RD_CYC (RD_CYC),
        .WP_CYC (WP_CYC),
        .HZ_CYC (HZ_CYC),
        .CNT_W  (CNT_W)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .req_we   (req_we),
        .be_any   (|req_be),
        .phase    (phase),
        .accept   (accept),
        .capture  (capture),
        .drive_en (drive_en),
        .ack      (ack)
    );

    asram_lanes #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .LANES  (LANES)
    ) u_lanes (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_be    (req_be),
        .capture   (capture),
        .dq_in     (mem_dq),
        .addr_q    (mem_addr),
        .wdata_q   (wdata_q),
        .be_q      (be_q),
        .rdata     (rdata)
    );

    assign busy       = (phase == PH_READ) || (phase == PH_WPULSE) || (phase == PH_WHOLD);
    assign mem_cs_n   = !busy;
    assign mem_oe_n   = (phase != PH_READ);
    assign mem_we_n   = (phase != PH_WPULSE);
    assign mem_lane_n = busy ? ~be_q : '1;
    assign mem_dq_oe  = drive_en;
    assign mem_dq     = mem_dq_oe ? wdata_q : {DATA_W{1'bz}};

    // window checker for the write-enable pulse width
    logic [CNT_W-1:0] we_low_cnt;
    always_ff @(posedge clk) begin
        if (rst)                 we_low_cnt <= '0;
        else if (!mem_we_n)      we_low_cnt <= (we_low_cnt == '1) ? we_low_cnt : we_low_cnt + 1'b1;
        else                     we_low_cnt <= '0;
    end

    // R4: write enable only inside a selected window
    p_we_in_cs_r4: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> !mem_cs_n);
    // R4: write ends on write enable while select is still low
    p_we_ends_first_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> !mem_cs_n);
    // R4: pulse long enough
    p_pulse_width_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> we_low_cnt >= CNT_W'(WP_CYC));
    // R6: never drive while the memory may be driving
    p_no_clash_r6: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> mem_oe_n && !mem_cs_n);
    // R6: drivers come on only after write enable has been low a while
    p_drive_late_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_dq_oe) |-> !mem_we_n && we_low_cnt >= CNT_W'(HZ_CYC));
    // R7: address and strobes stay put for a whole access
    p_addr_stable_r7: assert property (@(posedge clk) disable iff (rst)
        !mem_cs_n && $past(!mem_cs_n) |-> $stable(mem_addr) && $stable(mem_lane_n));

endmodule

// File: tb/asram_ctrl_tb.sv
`timescale 1ns/1ps
module asram_ctrl_tb;

    localparam int CLK_HALF = 5 / 2.0;
    localparam int NV = 11;
    // {we, addr[5:0], be[1:0], data[15:0]}
    localparam logic [24:0] VEC [NV] = '{
        {1'b1, 6'd1, 2'b11, 16'h1234},
        {1'b1, 6'd2, 2'b11, 16'hABCD},
        {1'b0, 6'd1, 2'b11, 16'h0000},
        {1'b0, 6'd2, 2'b01, 16'h0000},
        {1'b1, 6'd2, 2'b10, 16'h5566},
        {1'b0, 6'd2, 2'b10, 16'h0000},
        {1'b1, 6'd1, 2'b01, 16'h99EE},
        {1'b0, 6'd1, 2'b11, 16'h0000},
        {1'b1, 6'd3, 2'b00, 16'hFFFF},
        {1'b0, 6'd3, 2'b11, 16'h0000},
        {1'b0, 6'd5, 2'b00, 16'h0000}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0, req_we = 1'b0;
    logic [17:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic        ack, mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [15:0] rdata;
    logic [1:0]  mem_lane_n;
    logic [17:0] mem_addr;
    wire  [15:0] mem_dq;

    int checks = 0, errors = 0;
    logic [15:0] model [0:63];
    logic [15:0] shadow [0:63];
    logic        prev_rd = 1'b0;

    always #2.5 clk = ~clk;

    asram_ctrl u_dut (
        .clk(clk), .rst(rst), .req(req), .req_we(req_we), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_be(req_be), .ack(ack), .rdata(rdata),
        .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_lane_n(mem_lane_n), .mem_addr(mem_addr), .mem_dq(mem_dq),
        .mem_dq_oe(mem_dq_oe)
    );

    // memory model
    wire rd_on = (mem_cs_n === 1'b0) && (mem_oe_n === 1'b0) && (mem_we_n === 1'b1);
    assign mem_dq[7:0]  = (rd_on && mem_lane_n[0] === 1'b0) ? model[mem_addr[5:0]][7:0]  : 8'hzz;
    assign mem_dq[15:8] = (rd_on && mem_lane_n[1] === 1'b0) ? model[mem_addr[5:0]][15:8] : 8'hzz;

    always @(posedge mem_we_n) begin
        if (mem_cs_n === 1'b0) begin
            if (mem_lane_n[0] === 1'b0) model[mem_addr[5:0]][7:0]  = mem_dq[7:0];
            if (mem_lane_n[1] === 1'b0) model[mem_addr[5:0]][15:8] = mem_dq[15:8];
        end
    end

    task automatic check(input bit ok, input string req_tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req_tag, act, exp);
        end
    endtask

    task automatic run_op(input logic we, input logic [5:0] a, input logic [1:0] be, input logic [15:0] d);
        int lat, we_low, drv_low, exp_lat;
        bit clash, strobe_seen, addr_bad, turn_ok, hold_ok, hold_seen, prev_we_low;
        logic [15:0] exp_rd;
        exp_lat = (be == 2'b00) ? 1 : (!we ? 15 : (prev_rd ? 16 : 15));
        exp_rd  = {be[1] ? shadow[a][15:8] : 8'h00, be[0] ? shadow[a][7:0] : 8'h00};
        @(negedge clk);
        req = 1'b1; req_we = we; req_addr = {12'h000, a}; req_be = be; req_wdata = d;
        @(negedge clk);
        req = 1'b0;
        lat = 1; we_low = 0; drv_low = 0; clash = 0; strobe_seen = 0; addr_bad = 0;
        turn_ok = 1; hold_ok = 1; hold_seen = 0; prev_we_low = 0;
        forever begin
            if (mem_cs_n == 1'b0 || mem_lane_n != 2'b11 || mem_we_n == 1'b0) strobe_seen = 1;
            if (mem_dq_oe && !mem_oe_n) clash = 1;
            if (!mem_we_n) we_low++;
            if (!mem_we_n && mem_dq_oe) drv_low++;
            if (!mem_cs_n && (mem_addr != {12'h000, a} || mem_lane_n != ~be)) addr_bad = 1;
            if (lat == 1 && we && prev_rd && be != 2'b00 &&
                !(mem_cs_n && mem_oe_n && mem_we_n && mem_lane_n == 2'b11)) turn_ok = 0;
            if (prev_we_low && mem_we_n) begin
                hold_seen = 1;
                if (!(mem_cs_n == 1'b0 && mem_dq_oe && mem_dq === d && mem_addr == {12'h000, a}))
                    hold_ok = 0;
            end
            prev_we_low = !mem_we_n;
            if (ack) break;
            if (lat > 100) break;
            @(negedge clk);
            lat++;
        end
        check(lat == exp_lat, (be == 2'b00) ? "R9" : (we ? (prev_rd ? "R8" : "R7") : "R3"), lat, exp_lat);
        check(!clash, "R6", clash, 0);
        if (be == 2'b00) begin
            check(!strobe_seen, "R9", strobe_seen, 0);
            check(model[a] == shadow[a], "R9", model[a], shadow[a]);
        end else if (!we) begin
            check(rdata == exp_rd, "R3", rdata, exp_rd);
            check(!addr_bad, "R2", addr_bad, 0);
            check(we_low == 0, "R2", we_low, 0);
            prev_rd = 1'b1;
        end else begin
            if (be[0]) shadow[a][7:0]  = d[7:0];
            if (be[1]) shadow[a][15:8] = d[15:8];
            check(model[a] == shadow[a], "R5", model[a], shadow[a]);
            check(we_low == 13, "R4", we_low, 13);
            check(drv_low == 8, "R6", drv_low, 8);
            check(hold_seen && hold_ok, "R7", hold_ok, 1);
            check(!addr_bad, "R2", addr_bad, 0);
            check(turn_ok, "R8", turn_ok, 1);
            prev_rd = 1'b0;
        end
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int acks;
        for (int i = 0; i < 64; i++) begin
            model[i]  = 16'hC3C3 + 16'(i);
            shadow[i] = 16'hC3C3 + 16'(i);
        end
        repeat (4) @(negedge clk);
        check(mem_cs_n && mem_oe_n && mem_we_n && mem_lane_n == 2'b11 && !mem_dq_oe && !ack,
              "R1", {mem_cs_n, mem_oe_n, mem_we_n, mem_lane_n, mem_dq_oe, ack}, 7'b1111100);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check(mem_cs_n && mem_oe_n && mem_we_n && mem_lane_n == 2'b11 && !mem_dq_oe && !ack && rdata == 0,
              "R1", rdata, 0);

        for (int v = 0; v < NV; v++)
            run_op(VEC[v][24], VEC[v][23:18], VEC[v][17:16], VEC[v][15:0]);

        // R11: new request in the ack cycle is taken
        run_op(1'b0, 6'd1, 2'b11, 16'h0000);
        req = 1'b1; req_we = 1'b0; req_addr = 18'd2; req_be = 2'b11;
        @(negedge clk);
        req = 1'b0;
        acks = 0;
        for (int c = 0; c < 20; c++) begin
            if (ack) acks++;
            @(negedge clk);
        end
        check(acks == 1, "R11", acks, 1);
        check(rdata == shadow[2], "R11", rdata, shadow[2]);
        prev_rd = 1'b1;

        // R10: request during a busy read is dropped
        @(negedge clk);
        req = 1'b1; req_we = 1'b0; req_addr = 18'd4; req_be = 2'b11;
        @(negedge clk);
        req = 1'b0;
        repeat (3) @(negedge clk);
        req = 1'b1; req_we = 1'b1; req_addr = 18'd4; req_be = 2'b11; req_wdata = 16'h0000;
        @(negedge clk);
        req = 1'b0;
        acks = 0;
        for (int c = 0; c < 40; c++) begin
            if (ack) acks++;
            check(mem_we_n, "R10", mem_we_n, 1);
            @(negedge clk);
        end
        check(acks == 1, "R10", acks, 1);
        check(model[4] == shadow[4], "R10", model[4], shadow[4]);
        check(rdata == shadow[4], "R10", rdata, shadow[4]);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule